// File: doc/BRIEF.md
# Sleep Mode Controller with Timed Brown-out Disable

This block is the power-management control unit of a small microcontroller core. It holds two registers that software writes over a simple bus: a sleep control register, which carries a three-bit mode code and a sleep-enable bit, and the brown-out portion of a system control register. When the core signals that it has executed a sleep instruction, the block checks the sleep-enable bit and the mode code. If both allow it, the block enters sleep and drives exactly one mode output until a wake-up pulse arrives.

The brown-out detector can be switched off for the duration of a sleep, but only through a guarded sequence. Software first arms the sequence by writing both the disable bit and its unlock bit as 1 in a single write. This opens a short window in which a second write may set the disable bit. Once set, the disable bit counts through a settling delay and then a hold period, and after that it clears itself. A sleep entered during the hold period also drives the brown-out-off output, which stays high until wake-up.

The register read path is combinational from the address. It returns the live state of the self-clearing bits, so software can poll the sequence as it progresses.

Top module: `slpctl_top`

## Requirements
- R1: After reset both registers read 0x00, and `mode_oh` and `bod_off` are 0.
- R2: A write to address 0 stores data bits 3:0 in the sleep register (bits 3:1 = mode code, bit 0 = sleep enable). A read of address 0 returns those four bits, with bits 7:4 reading 0.
- R3: While running, a `sleep_exec` pulse with sleep enable = 1 and a valid code drives `mode_oh` one cycle later: code 000 sets bit 0, 001 sets bit 1, 010 sets bit 2, 011 sets bit 3, 110 sets bit 4. No more than one bit is ever set.
- R4: A `sleep_exec` pulse while sleep enable is 0 leaves `mode_oh` at 0.
- R5: A `sleep_exec` pulse with a reserved code (100, 101, 111) leaves `mode_oh` at 0.
- R6: While asleep, a `wake` pulse clears `mode_oh` and `bod_off` one cycle later. Until that pulse both outputs hold their values.
- R7: A write to address 1 with data bits 6 and 5 both 1 arms the sequence. Bit 5 of address 1 then reads 1 for the next four cycles and clears itself after that.
- R8: A write to address 1 with bit 6 = 1 and bit 5 = 0, accepted on any of the four clock edges after the arming write, sets the disable bit. Bit 6 of address 1 reads 1 from the next cycle.
- R9: The disable-bit write of R8 is ignored if it arrives on the fifth edge or later after arming, or if no arming write came before it.
- R10: Once set, the disable bit reads 1 for six cycles and then clears itself, with no further write.
- R11: `bod_off` is set at sleep entry only when the `sleep_exec` pulse is sampled on the fourth, fifth or sixth edge after the disable bit was set, which is its active phase.
- R12: While asleep, further `sleep_exec` pulses and changes to the sleep register leave `mode_oh` and `bod_off` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address (0 = sleep control, 1 = system control) |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| sleep_exec | input | 1 | Pulse from the core: sleep instruction executed |
| wake | input | 1 | Wake-up pulse |
| mode_oh | output | 5 | One-hot active sleep mode |
| bod_off | output | 1 | Brown-out detector switched off for this sleep |

## Verification
The bound checker watches several properties on every cycle. It checks that `mode_oh` is never more than one-hot, that `bod_off` never appears outside sleep, and that the mode holds steady until a wake pulse, which then clears it. It also checks that a request with sleep enable 0 or with a reserved code produces no sleep, and that the disable bit can only rise right after the unlock bit was set. The cycle-exact edges of the four-cycle window, the six-cycle lifetime of the disable bit and the three-cycle active phase in which a sleep turns the detector off can only be shown by the bench. It sweeps the gap between writes and the gap between setting the bit and sleeping across each boundary, and it sweeps every mode code with sleep enable both 0 and 1.

// File: rtl/slpctl_pkg.sv
package slpctl_pkg;

  localparam int unsigned NMODE = 5;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_SLEEP = 1'b1
  } slp_state_e;

  // Mode codes held in the sleep register (bits 3:1)
  localparam logic [2:0] CODE_IDLE  = 3'b000;
  localparam logic [2:0] CODE_ADCNR = 3'b001;
  localparam logic [2:0] CODE_PDOWN = 3'b010;
  localparam logic [2:0] CODE_PSAVE = 3'b011;
  localparam logic [2:0] CODE_STBY  = 3'b110;

  // One-hot mode vector; zero for reserved codes
  function automatic logic [NMODE-1:0] mode_decode(input logic [2:0] code);
    logic [NMODE-1:0] oh;
    oh = '0;
    case (code)
      CODE_IDLE:  oh[0] = 1'b1;
      CODE_ADCNR: oh[1] = 1'b1;
      CODE_PDOWN: oh[2] = 1'b1;
      CODE_PSAVE: oh[3] = 1'b1;
      CODE_STBY:  oh[4] = 1'b1;
      default:    oh    = '0;
    endcase
    return oh;
  endfunction

endpackage

// File: rtl/slpctl_regs.sv
module slpctl_regs #(
  parameter int unsigned          ADDR_W   = 2,
  parameter int unsigned          DATA_W   = 8,
  parameter logic [ADDR_W-1:0]    SLP_ADDR = '0,
  parameter logic [ADDR_W-1:0]    SYS_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              bods_bit,
  input  logic              unlock_bit,
  output logic [3:0]        slp_q,
  output logic              sys_wr,
  output logic              wr_bods,
  output logic              wr_unlock,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned BODS_POS   = 6;
  localparam int unsigned UNLOCK_POS = 5;

  logic       slp_en;
  logic [3:0] slp_d;
  logic       unused_wbits;

  // next-state
  always_comb begin
    slp_en = we && (addr == SLP_ADDR);
    slp_d  = wdata[3:0];
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      slp_q <= '0;
    else if (slp_en) slp_q <= slp_d;
  end

  assign sys_wr    = we && (addr == SYS_ADDR);
  assign wr_bods   = wdata[BODS_POS];
  assign wr_unlock = wdata[UNLOCK_POS];
  assign unused_wbits = ^{wdata[DATA_W-1:7], wdata[4]};

  // read mux
  always_comb begin
    rdata = '0;
    if (addr == SLP_ADDR) begin
      rdata[3:0] = slp_q;
    end else if (addr == SYS_ADDR) begin
      rdata[BODS_POS]   = bods_bit;
      rdata[UNLOCK_POS] = unlock_bit;
    end
  end

endmodule

// File: rtl/slpctl_bodseq.sv
module slpctl_bodseq #(
  parameter int unsigned WIN   = 4,
  parameter int unsigned DELAY = 3,
  parameter int unsigned HOLD  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_wr,
  input  logic wr_bods,
  input  logic wr_unlock,
  output logic unlock_bit,
  output logic bods_bit,
  output logic bods_active
);

  localparam int unsigned LIFE = DELAY + HOLD;
  localparam int unsigned WW   = $clog2(WIN + 1);
  localparam int unsigned LW   = $clog2(LIFE + 1);

  logic [WW-1:0] win_q, win_d;
  logic [LW-1:0] life_q, life_d;
  logic          win_en, life_en;
  logic          arm_req, set_req;

  // next-state: unlock window
  always_comb begin
    arm_req = sys_wr && wr_bods && wr_unlock;
    set_req = sys_wr && wr_bods && !wr_unlock && (win_q != '0);
    win_en  = sys_wr || (win_q != '0);
    win_d   = win_q;
    if (win_q != '0) win_d = win_q - 1'b1;
    if (arm_req)                   win_d = WW'(WIN);
    else if (sys_wr && !wr_unlock) win_d = '0;
  end

  // next-state: disable-bit lifetime
  always_comb begin
    life_en = set_req || (life_q != '0);
    life_d  = life_q;
    if (life_q != '0) life_d = life_q - 1'b1;
    if (set_req)      life_d = LW'(LIFE);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (win_en) win_q <= win_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       life_q <= '0;
    else if (life_en) life_q <= life_d;
  end

  assign unlock_bit  = (win_q != '0);
  assign bods_bit    = (life_q != '0);
  assign bods_active = (life_q != '0) && (life_q <= LW'(HOLD));

endmodule

// File: rtl/slpctl_fsm.sv
module slpctl_fsm
  import slpctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_exec,
  input  logic             wake,
  input  logic             se,
  input  logic [2:0]       mode_code,
  input  logic             bods_active,
  output logic [NMODE-1:0] mode_oh,
  output logic             bod_off
);

  slp_state_e       st_q, st_d;
  logic [NMODE-1:0] oh_d, dec;
  logic             bo_d, upd;

  // next-state
  always_comb begin
    dec  = mode_decode(mode_code);
    st_d = st_q;
    oh_d = mode_oh;
    bo_d = bod_off;
    upd  = 1'b0;
    case (st_q)
      ST_RUN: begin
        if (sleep_exec && se && (dec != '0)) begin
          st_d = ST_SLEEP;
          oh_d = dec;
          bo_d = bods_active;
          upd  = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (wake) begin
          st_d = ST_RUN;
          oh_d = '0;
          bo_d = 1'b0;
          upd  = 1'b1;
        end
      end
      default: begin
        st_d = ST_RUN;
        oh_d = '0;
        bo_d = 1'b0;
        upd  = 1'b1;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      mode_oh <= '0;
      bod_off <= 1'b0;
    end else if (upd) begin
      st_q    <= st_d;
      mode_oh <= oh_d;
      bod_off <= bo_d;
    end
  end

endmodule

// File: rtl/slpctl_top.sv
module slpctl_top
  import slpctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WIN    = 4,
  parameter int unsigned DELAY  = 3,
  parameter int unsigned HOLD   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sleep_exec,
  input  logic              wake,
  output logic [NMODE-1:0]  mode_oh,
  output logic              bod_off
);

  logic [3:0] slp_q;
  logic       sys_wr, wr_bods, wr_unlock;
  logic       unlock_bit, bods_bit, bods_active;

  slpctl_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SLP_ADDR (ADDR_W'(0)),
    .SYS_ADDR (ADDR_W'(1))
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .we         (reg_we),
    .bods_bit   (bods_bit),
    .unlock_bit (unlock_bit),
    .slp_q      (slp_q),
    .sys_wr     (sys_wr),
    .wr_bods    (wr_bods),
    .wr_unlock  (wr_unlock),
    .rdata      (reg_rdata)
  );

  slpctl_bodseq #(
    .WIN   (WIN),
    .DELAY (DELAY),
    .HOLD  (HOLD)
  ) u_bodseq (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_wr      (sys_wr),
    .wr_bods     (wr_bods),
    .wr_unlock   (wr_unlock),
    .unlock_bit  (unlock_bit),
    .bods_bit    (bods_bit),
    .bods_active (bods_active)
  );

  slpctl_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_exec  (sleep_exec),
    .wake        (wake),
    .se          (slp_q[0]),
    .mode_code   (slp_q[3:1]),
    .bods_active (bods_active),
    .mode_oh     (mode_oh),
    .bod_off     (bod_off)
  );

endmodule

// File: rtl/slpctl_chk.sv
module slpctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_exec,
  input logic       wake,
  input logic [4:0] mode_oh,
  input logic       bod_off,
  input logic [3:0] slp_q,
  input logic       unlock_bit,
  input logic       bods_bit
);

  logic rsv_code;
  assign rsv_code = slp_q[3] && (slp_q[3:1] != 3'b110);

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode_oh));

  p_nose_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh == '0 && sleep_exec && !slp_q[0]) |=> (mode_oh == '0));

  p_rsv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh == '0 && sleep_exec && rsv_code) |=> (mode_oh == '0));

  p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_oh != '0) && wake) |=> (mode_oh == '0 && !bod_off));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_oh != '0) && !wake) |=> ($stable(mode_oh) && $stable(bod_off)));

  p_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bods_bit) |-> $past(unlock_bit));

  p_life_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bods_bit) |=> bods_bit);

  p_bodoff_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bod_off |-> (mode_oh != '0));

endmodule

bind slpctl_top slpctl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sleep_exec (sleep_exec),
  .wake       (wake),
  .mode_oh    (mode_oh),
  .bod_off    (bod_off),
  .slp_q      (slp_q),
  .unlock_bit (unlock_bit),
  .bods_bit   (bods_bit)
);

// File: tb/slpctl_top_test.sv
module slpctl_top_test;

  localparam int CLK_P = 10;
  localparam int WD_CYC = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic [7:0] reg_rdata;
  logic       sleep_exec;
  logic       wake;
  logic [4:0] mode_oh;
  logic       bod_off;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  slpctl_top uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_we     (reg_we),
    .reg_rdata  (reg_rdata),
    .sleep_exec (sleep_exec),
    .wake       (wake),
    .mode_oh    (mode_oh),
    .bod_off    (bod_off)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_oh(input int code, input int se);
    if (se == 0) return 0;
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      6: return 16;
      default: return 0;
    endcase
  endfunction

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic pulse_sleep();
    sleep_exec = 1'b1;
    @(posedge clk); @(negedge clk);
    sleep_exec = 1'b0;
  endtask

  task automatic pulse_wake();
    wake = 1'b1;
    @(posedge clk); @(negedge clk);
    wake = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_we = 1'b0;
    sleep_exec = 1'b0; wake = 1'b0;
    idle(3);
    // R1 reset state
    rd(2'd0, v); chk("R1 sleep reg", v, 0);
    rd(2'd1, v); chk("R1 sys reg", v, 0);
    chk("R1 mode_oh", int'(mode_oh), 0);
    chk("R1 bod_off", int'(bod_off), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R2 register storage
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 write FF", v, 8'h0F);
    wr(2'd0, 8'hA5); rd(2'd0, v); chk("R2 write A5", v, 8'h05);
    wr(2'd0, 8'h00); rd(2'd0, v); chk("R2 write 00", v, 0);

    // R3 R4 R5 sweep of every code with sleep enable 0 and 1
    for (int se = 0; se < 2; se++) begin
      for (int code = 0; code < 8; code++) begin
        wr(2'd0, 8'((code << 1) | se));
        pulse_sleep();
        if (se == 0)
          chk("R4 no sleep without enable", int'(mode_oh), 0);
        else if (exp_oh(code, se) == 0)
          chk("R5 reserved code", int'(mode_oh), 0);
        else
          chk("R3 mode one-hot", int'(mode_oh), exp_oh(code, se));
        chk("R11 no bod_off without sequence", int'(bod_off), 0);
        pulse_wake();
        chk("R6 wake clears", int'(mode_oh), 0);
      end
    end

    // R12 requests and register changes while asleep
    wr(2'd0, 8'h01);
    pulse_sleep();
    chk("R3 idle entry", int'(mode_oh), 1);
    wr(2'd0, 8'h05);
    pulse_sleep();
    chk("R12 ignored while asleep", int'(mode_oh), 1);
    idle(3);
    chk("R6 held until wake", int'(mode_oh), 1);
    pulse_wake();
    chk("R6 released", int'(mode_oh), 0);

    // R7 unlock bit lifetime
    wr(2'd1, 8'h60);
    for (int i = 0; i < 6; i++) begin
      rd(2'd1, v);
      chk("R7 unlock bit", (v >> 5) & 1, (i < 4) ? 1 : 0);
      @(negedge clk);
    end

    // R9 set without arming
    wr(2'd1, 8'h40);
    rd(2'd1, v); chk("R9 unarmed write ignored", (v >> 6) & 1, 0);
    idle(8);

    // R8 R9 window sweep
    for (int g = 0; g < 6; g++) begin
      wr(2'd1, 8'h60);
      idle(g);
      wr(2'd1, 8'h40);
      rd(2'd1, v);
      if (g <= 3) chk("R8 set within window", (v >> 6) & 1, 1);
      else        chk("R9 late write ignored", (v >> 6) & 1, 0);
      idle(10);
    end

    // R10 disable bit lifetime
    wr(2'd1, 8'h60);
    wr(2'd1, 8'h40);
    for (int i = 0; i < 8; i++) begin
      rd(2'd1, v);
      chk("R10 disable bit lifetime", (v >> 6) & 1, (i <= 5) ? 1 : 0);
      @(negedge clk);
    end

    // R11 active-phase sweep, power-down with sleep enable
    wr(2'd0, 8'h05);
    for (int h = 0; h < 8; h++) begin
      wr(2'd1, 8'h60);
      wr(2'd1, 8'h40);
      idle(h);
      pulse_sleep();
      chk("R11 bod_off phase", int'(bod_off), (h >= 3 && h <= 5) ? 1 : 0);
      chk("R3 power-down entry", int'(mode_oh), 4);
      idle(2);
      chk("R6 bod_off held", int'(bod_off), (h >= 3 && h <= 5) ? 1 : 0);
      pulse_wake();
      chk("R6 bod_off released", int'(bod_off), 0);
      idle(8);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule